// File: doc/BRIEF.md
# Cache-Side Coherence Engine

This block is the controller that sits beside one cache in a directory-based coherence scheme where writers push their data home. It keeps a small fully-associative set of lines. Each line holds an address tag, a data word and one of four states: absent, clean, dirty, or waiting for a writeback reply. On the processor side it serves four operations: load, store, commit and reconcile. On the home side it sends cache requests, purges and writebacks, and it receives fills, writeback acknowledges and flush acknowledges.

The processor holds a request steady on `req_*` until the engine raises `req_ready_o`. In that same cycle the request retires, and `rsp_data_o` carries the result. A request that cannot retire yet makes the engine send whatever home message will let it progress. A load or store miss sends a cache request, or it first evicts a victim when no line is free. A commit to a dirty line sends a writeback. Outbound messages sit in a single register with a valid/ready handshake. The inbound port is always ready and acts on each message in the cycle it arrives.

Top module: `cc_engine`

## Requirements
- R1: After reset all lines are absent, no outbound message is pending, no fill is awaited, and `in_ready_o` is high at all times.
- R2: A load (op 0) that hits a clean or dirty line retires in the cycle it is presented, returns the line's data and leaves the line state unchanged.
- R3: A store (op 1) that hits a clean or dirty line retires in the cycle it is presented, echoes `req_data_i` on `rsp_data_o`, writes that value and makes the line dirty.
- R4: A commit (op 2) retires at once on an absent or clean line. On a dirty line it sends a writeback (out kind 2) carrying the line's address and data, and it retires only once the line is no longer dirty or pending.
- R5: A reconcile (op 3) retires at once on an absent, clean or dirty line.
- R6: No request retires while its address is held by a line that is waiting for a writeback reply.
- R7: A writeback acknowledge (in kind 1) to a pending line makes it clean and keeps its data. A flush acknowledge (in kind 2) to a pending line removes it.
- R8: A load or store miss with a free line sends one cache request (out kind 0) for the address, then waits. It retires after the fill arrives.
- R9: A fill (in kind 0) installs the line clean only when it matches the awaited address and that address is absent. Any other fill is ignored.
- R10: A miss with no free line evicts the lowest-index clean or dirty line. A clean victim is purged (out kind 1) and becomes absent when the purge is queued. A dirty victim is written back (out kind 2) and becomes pending.
- R11: An outbound message stays valid with unchanged kind, address and data until `out_ready_i` is high.
- R12: An acknowledge to an address that is not pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Processor request present |
| req_op_i | input | 2 | 0 load, 1 store, 2 commit, 3 reconcile |
| req_addr_i | input | AW | Request address |
| req_data_i | input | DW | Store data |
| req_ready_o | output | 1 | Request retires this cycle |
| rsp_data_o | output | DW | Load result or store echo, valid with ready |
| out_valid_o | output | 1 | Outbound message valid |
| out_ready_i | input | 1 | Home accepts outbound message |
| out_kind_o | output | 2 | 0 cache request, 1 purge, 2 writeback |
| out_addr_o | output | AW | Message address |
| out_data_o | output | DW | Writeback data |
| in_valid_i | input | 1 | Inbound message valid |
| in_ready_o | output | 1 | Always high |
| in_kind_i | input | 2 | 0 fill, 1 writeback ack, 2 flush ack |
| in_addr_i | input | AW | Message address |
| in_data_i | input | DW | Fill data |

## Verification
The bench builds the engine at its defaults: four lines, 8-bit addresses and 16-bit data. Four lines fill after four distinct misses, so a fifth address exercises both the purge and the writeback victim paths within a few dozen cycles. The 8-bit address space is small enough for the bench's home model to keep a full memory image, so every fill and writeback value can be predicted. The home model answers writebacks alternately with each acknowledge kind and can be held back. This reaches the pending-line stalls, the back-to-back eviction of a second victim, and stray fills and acknowledges.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    LN_ABSENT = 2'd0,
    LN_CLEAN  = 2'd1,
    LN_DIRTY  = 2'd2,
    LN_WBPEND = 2'd3
  } line_st_e;

  localparam logic [1:0] OP_LOAD   = 2'd0;
  localparam logic [1:0] OP_STORE  = 2'd1;
  localparam logic [1:0] OP_COMMIT = 2'd2;
  localparam logic [1:0] OP_RECON  = 2'd3;

  localparam logic [1:0] OUT_CREQ  = 2'd0;
  localparam logic [1:0] OUT_PURGE = 2'd1;
  localparam logic [1:0] OUT_WB    = 2'd2;

  localparam logic [1:0] IN_FILL   = 2'd0;
  localparam logic [1:0] IN_WBACK  = 2'd1;
  localparam logic [1:0] IN_FLACK  = 2'd2;
endpackage

// File: rtl/cc_first_set.sv
module cc_first_set #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/cc_lookup.sv
module cc_lookup #(
  parameter int LINES = 4,
  parameter int AW    = 8,
  localparam int IW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic [LINES-1:0][1:0]    st_i,
  input  logic [LINES-1:0][AW-1:0] tag_i,
  input  logic [AW-1:0]            addr_i,
  output logic                     hit_o,
  output logic [IW-1:0]            idx_o
);
  logic [LINES-1:0] match;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = (st_i[g] != cc_pkg::LN_ABSENT) && (tag_i[g] == addr_i);
  end

  cc_first_set #(.N(LINES)) u_enc (
    .vec_i  (match),
    .found_o(hit_o),
    .idx_o  (idx_o)
  );
endmodule

// File: rtl/cc_engine.sv
module cc_engine
  import cc_pkg::*;
#(
  parameter int LINES = 4,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  output logic          req_ready_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [1:0]    out_kind_o,
  output logic [AW-1:0] out_addr_o,
  output logic [DW-1:0] out_data_o,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [1:0]    in_kind_i,
  input  logic [AW-1:0] in_addr_i,
  input  logic [DW-1:0] in_data_i
);
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1;

  logic [LINES-1:0][1:0]    st_q;
  logic [LINES-1:0][AW-1:0] tag_q;
  logic [LINES-1:0][DW-1:0] dat_q;

  logic          out_full_q;
  logic [1:0]    out_kind_q;
  logic [AW-1:0] out_addr_q;
  logic [DW-1:0] out_data_q;

  logic          fill_wait_q;
  logic [AW-1:0] fill_addr_q;
  logic [IW-1:0] fill_slot_q;

  logic          req_hit, in_hit, free_found, vict_found;
  logic [IW-1:0] req_idx, in_idx, free_idx, vict_idx;
  logic [LINES-1:0] free_vec, vict_vec;

  cc_lookup #(.LINES(LINES), .AW(AW)) u_req_lu (
    .st_i(st_q), .tag_i(tag_q), .addr_i(req_addr_i), .hit_o(req_hit), .idx_o(req_idx)
  );
  cc_lookup #(.LINES(LINES), .AW(AW)) u_in_lu (
    .st_i(st_q), .tag_i(tag_q), .addr_i(in_addr_i), .hit_o(in_hit), .idx_o(in_idx)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_cls
    assign free_vec[g] = (st_q[g] == LN_ABSENT);
    assign vict_vec[g] = (st_q[g] == LN_CLEAN) || (st_q[g] == LN_DIRTY);
  end

  cc_first_set #(.N(LINES)) u_free (.vec_i(free_vec), .found_o(free_found), .idx_o(free_idx));
  cc_first_set #(.N(LINES)) u_vict (.vec_i(vict_vec), .found_o(vict_found), .idx_o(vict_idx));

  // request side
  logic [1:0] req_st;
  logic       can_retire, store_fire;
  assign req_st = req_hit ? st_q[req_idx] : LN_ABSENT;

  always_comb begin
    unique case (req_op_i)
      OP_LOAD, OP_STORE: can_retire = (req_st == LN_CLEAN) || (req_st == LN_DIRTY);
      OP_COMMIT:         can_retire = (req_st == LN_ABSENT) || (req_st == LN_CLEAN);
      default:           can_retire = (req_st != LN_WBPEND);
    endcase
  end

  assign req_ready_o = req_valid_i && can_retire;
  assign rsp_data_o  = (req_op_i == OP_STORE) ? req_data_i : dat_q[req_idx];
  assign store_fire  = req_ready_o && (req_op_i == OP_STORE);

  // outbound message selection
  logic          ld_msg;
  logic [1:0]    ld_kind;
  logic [AW-1:0] ld_addr;
  logic [DW-1:0] ld_data;
  logic [IW-1:0] ld_idx;

  always_comb begin
    ld_msg  = 1'b0;
    ld_kind = OUT_CREQ;
    ld_addr = req_addr_i;
    ld_data = '0;
    ld_idx  = req_idx;
    if (req_valid_i && !out_full_q) begin
      if ((req_op_i == OP_LOAD || req_op_i == OP_STORE) && !req_hit && !fill_wait_q) begin
        if (free_found) begin
          ld_msg = 1'b1;
        end else if (vict_found) begin
          ld_msg  = 1'b1;
          ld_idx  = vict_idx;
          ld_kind = (st_q[vict_idx] == LN_CLEAN) ? OUT_PURGE : OUT_WB;
          ld_addr = tag_q[vict_idx];
          ld_data = dat_q[vict_idx];
        end
      end else if (req_op_i == OP_COMMIT && req_st == LN_DIRTY) begin
        ld_msg  = 1'b1;
        ld_kind = OUT_WB;
        ld_data = dat_q[req_idx];
      end
    end
  end

  // inbound decode
  logic [1:0] in_st;
  logic       fill_ok, wback_ok, flack_ok;
  assign in_ready_o = 1'b1;
  assign in_st      = in_hit ? st_q[in_idx] : LN_ABSENT;
  assign fill_ok    = in_valid_i && in_kind_i == IN_FILL && fill_wait_q &&
                      in_addr_i == fill_addr_q && !in_hit;
  assign wback_ok   = in_valid_i && in_kind_i == IN_WBACK && in_st == LN_WBPEND;
  assign flack_ok   = in_valid_i && in_kind_i == IN_FLACK && in_st == LN_WBPEND;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      tag_q <= '0;
      dat_q <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (ld_msg && ld_kind != OUT_CREQ && ld_idx == IW'(i))
          st_q[i] <= (ld_kind == OUT_PURGE) ? LN_ABSENT : LN_WBPEND;
        if (store_fire && req_idx == IW'(i)) begin
          st_q[i]  <= LN_DIRTY;
          dat_q[i] <= req_data_i;
        end
        if (fill_ok && fill_slot_q == IW'(i)) begin
          st_q[i]  <= LN_CLEAN;
          tag_q[i] <= in_addr_i;
          dat_q[i] <= in_data_i;
        end
        if ((wback_ok || flack_ok) && in_idx == IW'(i))
          st_q[i] <= wback_ok ? LN_CLEAN : LN_ABSENT;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_full_q  <= 1'b0;
      out_kind_q  <= OUT_CREQ;
      out_addr_q  <= '0;
      out_data_q  <= '0;
      fill_wait_q <= 1'b0;
      fill_addr_q <= '0;
      fill_slot_q <= '0;
    end else begin
      if (ld_msg) begin
        out_full_q <= 1'b1;
        out_kind_q <= ld_kind;
        out_addr_q <= ld_addr;
        out_data_q <= ld_data;
      end else if (out_ready_i) begin
        out_full_q <= 1'b0;
      end
      if (ld_msg && ld_kind == OUT_CREQ) begin
        fill_wait_q <= 1'b1;
        fill_addr_q <= req_addr_i;
        fill_slot_q <= free_idx;
      end else if (fill_ok) begin
        fill_wait_q <= 1'b0;
      end
    end
  end

  assign out_valid_o = out_full_q;
  assign out_kind_o  = out_kind_q;
  assign out_addr_o  = out_addr_q;
  assign out_data_o  = out_data_q;
endmodule

// File: rtl/cc_engine_chk.sv
module cc_engine_chk
  import cc_pkg::*;
#(
  parameter int LINES = 4,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_valid_i,
  input logic [1:0]               req_op_i,
  input logic [AW-1:0]            req_addr_i,
  input logic [DW-1:0]            req_data_i,
  input logic                     req_ready_o,
  input logic                     out_valid_o,
  input logic                     out_ready_i,
  input logic [1:0]               out_kind_o,
  input logic [AW-1:0]            out_addr_o,
  input logic [DW-1:0]            out_data_o,
  input logic                     in_valid_i,
  input logic [1:0]               in_kind_i,
  input logic [AW-1:0]            in_addr_i,
  input logic [LINES-1:0][1:0]    st_i,
  input logic [LINES-1:0][AW-1:0] tag_i,
  input logic [LINES-1:0][DW-1:0] dat_i
);
  logic [AW-1:0]    prv_addr;
  logic [DW-1:0]    prv_data;
  logic             req_wbp, out_wbp, out_present, stored_ok, dup;
  logic [LINES-1:0] in_wbp_vec, clean_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prv_addr <= '0;
      prv_data <= '0;
    end else begin
      prv_addr <= req_addr_i;
      prv_data <= req_data_i;
    end
  end

  always_comb begin
    req_wbp = 1'b0; out_wbp = 1'b0; out_present = 1'b0; stored_ok = 1'b0; dup = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      in_wbp_vec[i] = st_i[i] == LN_WBPEND && tag_i[i] == in_addr_i;
      clean_vec[i]  = st_i[i] == LN_CLEAN;
      if (st_i[i] == LN_WBPEND && tag_i[i] == req_addr_i) req_wbp = 1'b1;
      if (st_i[i] == LN_WBPEND && tag_i[i] == out_addr_o) out_wbp = 1'b1;
      if (st_i[i] != LN_ABSENT && tag_i[i] == out_addr_o) out_present = 1'b1;
      if (st_i[i] == LN_DIRTY && tag_i[i] == prv_addr && dat_i[i] == prv_data) stored_ok = 1'b1;
      for (int j = i + 1; j < LINES; j++)
        if (st_i[i] != LN_ABSENT && st_i[j] != LN_ABSENT && tag_i[i] == tag_i[j]) dup = 1'b1;
    end
  end

  a_r11_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_kind_o) &&
                                    $stable(out_addr_o) && $stable(out_data_o));

  a_r6_no_retire_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |-> !req_wbp);

  a_r3_store_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_op_i == OP_STORE |=> stored_ok);

  a_r7_wback_cleans: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_kind_i == IN_WBACK && (|in_wbp_vec) |=>
      ((clean_vec & $past(in_wbp_vec)) == $past(in_wbp_vec)));

  a_r10_wb_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_kind_o == OUT_WB |-> out_wbp);

  a_r10_purge_gone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_kind_o == OUT_PURGE |-> !out_present);

  a_r9_unique_tags: assert property (@(posedge clk_i) disable iff (!rst_ni) !dup);
endmodule

bind cc_engine cc_engine_chk #(.LINES(LINES), .AW(AW), .DW(DW)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_op_i, .req_addr_i, .req_data_i, .req_ready_o,
  .out_valid_o, .out_ready_i, .out_kind_o, .out_addr_o, .out_data_o,
  .in_valid_i, .in_kind_i, .in_addr_i,
  .st_i(st_q), .tag_i(tag_q), .dat_i(dat_q)
);

// File: tb/cc_engine_test.sv
module cc_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_op_i = 2'd0;
  logic [7:0]  req_addr_i = 8'd0;
  logic [15:0] req_data_i = 16'd0;
  logic        req_ready_o;
  logic [15:0] rsp_data_o;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [1:0]  out_kind_o;
  logic [7:0]  out_addr_o;
  logic [15:0] out_data_o;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [1:0]  in_kind_i = 2'd0;
  logic [7:0]  in_addr_i = 8'd0;
  logic [15:0] in_data_i = 16'd0;

  always #5 clk = ~clk;

  cc_engine uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i, .req_op_i, .req_addr_i, .req_data_i, .req_ready_o, .rsp_data_o,
    .out_valid_o, .out_ready_i, .out_kind_o, .out_addr_o, .out_data_o,
    .in_valid_i, .in_ready_o, .in_kind_i, .in_addr_i, .in_data_i
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int          m_st[4];
  logic [7:0]  m_tag[4];
  logic [15:0] m_dat[4];
  bit          m_full, m_fw;
  int          m_kind, m_fslot;
  logic [7:0]  m_addr, m_faddr;
  logic [15:0] m_data;
  // home model
  logic [15:0] mem[256];
  logic [25:0] hq[$];
  bit          home_hold = 1'b0;
  bit          ack_flush = 1'b0;

  function automatic int find(input logic [7:0] a);
    for (int i = 0; i < 4; i++) if (m_st[i] != 0 && m_tag[i] == a) return i;
    return -1;
  endfunction

  int hi, hs, ii, fi, vi, lk, lidx;
  bit rt, ld, fill_ok;
  logic [7:0]  la;
  logic [15:0] ldat;

  always @(negedge clk) begin
    if (rst_n) begin
      check("R1 in_ready", in_ready_o, 1);
      hi = find(req_addr_i);
      hs = (hi >= 0) ? m_st[hi] : 0;
      case (req_op_i)
        2'd0, 2'd1: rt = (hs == 1 || hs == 2);
        2'd2:       rt = (hs == 0 || hs == 1);
        default:    rt = (hs != 3);
      endcase
      check("R6 req_ready", req_ready_o, req_valid_i && rt);
      if (req_valid_i && rt && req_op_i == 2'd0) check("R2 load data", rsp_data_o, m_dat[hi]);
      if (req_valid_i && rt && req_op_i == 2'd1) check("R3 store echo", rsp_data_o, req_data_i);
      check("R11 out_valid", out_valid_o, m_full);
      if (m_full) begin
        check("R10 out_kind", out_kind_o, m_kind);
        check("R8 out_addr", out_addr_o, m_addr);
        if (m_kind == 2) check("R4 wb data", out_data_o, m_data);
      end
      // next state: decision from current state
      ld = 1'b0; lk = 0; la = req_addr_i; ldat = 16'd0; lidx = hi;
      if (req_valid_i && !m_full) begin
        if (req_op_i <= 2'd1 && hi < 0 && !m_fw) begin
          fi = -1; vi = -1;
          for (int i = 3; i >= 0; i--) begin
            if (m_st[i] == 0) fi = i;
            if (m_st[i] == 1 || m_st[i] == 2) vi = i;
          end
          if (fi >= 0) begin
            ld = 1'b1;
          end else if (vi >= 0) begin
            ld = 1'b1; lidx = vi; lk = (m_st[vi] == 1) ? 1 : 2;
            la = m_tag[vi]; ldat = m_dat[vi];
          end
        end else if (req_op_i == 2'd2 && hs == 2) begin
          ld = 1'b1; lk = 2; ldat = m_dat[hi];
        end
      end
      ii = find(in_addr_i);
      fill_ok = in_valid_i && in_kind_i == 2'd0 && m_fw && in_addr_i == m_faddr && ii < 0;
      if (m_full && out_ready_i) begin
        m_full = 1'b0;
        if (m_kind == 0) hq.push_back({2'd0, m_addr, mem[m_addr]});
        else if (m_kind == 2) begin
          mem[m_addr] = m_data;
          hq.push_back({ack_flush ? 2'd2 : 2'd1, m_addr, 16'd0});
          ack_flush = !ack_flush;
        end
      end
      if (req_valid_i && rt && req_op_i == 2'd1) begin
        m_st[hi] = 2; m_dat[hi] = req_data_i;
      end
      if (ld) begin
        m_full = 1'b1; m_kind = lk; m_addr = la; m_data = ldat;
        if (lk == 0) begin m_fw = 1'b1; m_faddr = req_addr_i; m_fslot = fi; end
        else m_st[lidx] = (lk == 1) ? 0 : 3;
      end
      if (in_valid_i) begin
        if (fill_ok) begin
          m_st[m_fslot] = 1; m_tag[m_fslot] = in_addr_i; m_dat[m_fslot] = in_data_i; m_fw = 1'b0;
        end else if (in_kind_i != 2'd0 && ii >= 0 && m_st[ii] == 3) begin
          m_st[ii] = (in_kind_i == 2'd1) ? 1 : 0;
        end
        void'(hq.pop_front());
      end
    end
  end

  // home driver
  always @(posedge clk) begin
    #1;
    in_valid_i = rst_n && !home_hold && hq.size() > 0;
    if (hq.size() > 0) {in_kind_i, in_addr_i, in_data_i} = hq[0];
  end

  task automatic run_req(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d,
                         output logic [15:0] r, output int cyc);
    @(posedge clk); #2;
    req_valid_i = 1'b1; req_op_i = op; req_addr_i = a; req_data_i = d;
    cyc = 0; r = 16'd0;
    forever begin
      @(negedge clk);
      cyc++;
      if (req_ready_o) begin r = rsp_data_o; break; end
      if (cyc > 300) begin check("request timeout", 0, 1); break; end
    end
    @(posedge clk); #2;
    req_valid_i = 1'b0;
  endtask

  task automatic finish_test;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_test();
  end

  initial begin
    logic [15:0] r;
    int c;
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 257) ^ 16'h5a5a;
    for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
    m_full = 0; m_fw = 0; m_kind = 0; m_fslot = 0; m_addr = 0; m_faddr = 0; m_data = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset out_valid", out_valid_o, 0);
    check("R1 reset in_ready", in_ready_o, 1);

    run_req(2'd3, 8'h99, 16'd0, r, c); check("R5 reconcile absent", c, 1);
    run_req(2'd2, 8'h99, 16'd0, r, c); check("R4 commit absent", c, 1);

    run_req(2'd0, 8'h10, 16'd0, r, c);
    check("R8 miss fill data", r, mem[8'h10]);
    check("R8 miss waits", int'(c > 2), 1);
    run_req(2'd3, 8'h10, 16'd0, r, c); check("R5 reconcile clean", c, 1);
    run_req(2'd2, 8'h10, 16'd0, r, c); check("R4 commit clean", c, 1);

    run_req(2'd1, 8'h10, 16'hbeef, r, c); check("R3 store hit", c, 1);
    run_req(2'd0, 8'h10, 16'd0, r, c);
    check("R2 load dirty", r, 16'hbeef); check("R2 load hit latency", c, 1);
    run_req(2'd3, 8'h10, 16'd0, r, c); check("R5 reconcile dirty", c, 1);

    run_req(2'd2, 8'h10, 16'd0, r, c);
    check("R4 commit dirty waits", int'(c > 1), 1);
    check("R4 writeback reached home", mem[8'h10], 16'hbeef);
    run_req(2'd0, 8'h10, 16'd0, r, c);
    check("R7 wback keeps line", c, 1); check("R7 wback keeps data", r, 16'hbeef);

    run_req(2'd0, 8'h20, 16'd0, r, c); check("R8 fill 20", r, mem[8'h20]);
    run_req(2'd0, 8'h30, 16'd0, r, c); check("R8 fill 30", r, mem[8'h30]);
    run_req(2'd1, 8'h40, 16'h4444, r, c); check("R8 store miss echo", r, 16'h4444);
    run_req(2'd1, 8'h20, 16'h2222, r, c);

    // full: clean victim at slot 0 is purged
    run_req(2'd0, 8'h50, 16'd0, r, c); check("R10 purge victim fill", r, mem[8'h50]);
    run_req(2'd0, 8'h10, 16'd0, r, c);
    check("R10 purged line refetched", int'(c > 1), 1);
    check("R10 purged value", r, 16'hbeef);

    // dirty victims: writebacks, second acked by flush
    run_req(2'd1, 8'h10, 16'h1111, r, c);
    run_req(2'd0, 8'h60, 16'd0, r, c); check("R10 wb victim fill", r, mem[8'h60]);
    check("R10 victim written home", mem[8'h10], 16'h1111);
    run_req(2'd0, 8'h10, 16'd0, r, c);
    check("R7 flushed line refetched", r, 16'h1111);

    // stall on pending line
    run_req(2'd1, 8'h30, 16'h3333, r, c);
    home_hold = 1'b1;
    @(posedge clk); #2;
    req_valid_i = 1'b1; req_op_i = 2'd2; req_addr_i = 8'h30;
    repeat (4) @(negedge clk);
    @(posedge clk); #2;
    req_op_i = 2'd1; req_data_i = 16'h7777;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R6 stall on pending", req_ready_o, 0);
    end
    @(posedge clk); #2;
    req_valid_i = 1'b0;
    home_hold = 1'b0;
    run_req(2'd1, 8'h30, 16'h7777, r, c);
    check("R6 retires after ack", r, 16'h7777);

    // backpressure on outbound
    out_ready_i = 1'b0;
    @(posedge clk); #2;
    req_valid_i = 1'b1; req_op_i = 2'd0; req_addr_i = 8'h70;
    repeat (6) @(negedge clk);
    check("R11 held message", out_valid_o, 1);
    @(posedge clk); #2;
    req_valid_i = 1'b0;
    out_ready_i = 1'b1;
    run_req(2'd0, 8'h70, 16'd0, r, c); check("R11 after release", r, mem[8'h70]);

    // stray fill and acks
    hq.push_back({2'd0, 8'h77, 16'h1234});
    repeat (4) @(posedge clk);
    run_req(2'd0, 8'h77, 16'd0, r, c); check("R9 stray fill ignored", r, mem[8'h77]);
    hq.push_back({2'd2, 8'h77, 16'd0});
    hq.push_back({2'd1, 8'h77, 16'd0});
    repeat (5) @(posedge clk);
    run_req(2'd0, 8'h77, 16'd0, r, c);
    check("R12 stray ack keeps line", c, 1);
    check("R12 stray ack keeps data", r, mem[8'h77]);

    repeat (10) @(posedge clk);
    finish_test();
  end
endmodule